// File: doc/BRIEF.md
# Four-Channel Reload PWM Timer with Break

The block is a free-running 12-bit up-counter shared by four pulse-width channels. Software programs a reload value. The counter climbs from that value to the all-ones count and then reloads, so the reload value sets the PWM period: the period is 4096 minus the reload value, in clock cycles. Each channel compares the counter against its own duty value. A channel with normal polarity drives its pin high from the start of the period until the counter reaches the duty value, and low for the rest of the period.

Each channel has an enable bit, a polarity bit and a compare flag. Reading the channel's status register clears the flag. Duty and enable changes are held back until the next overflow, so a period never contains a mix of old and new settings.

An active-low break pin, or a software-writable break bit, drives every enabled output to its inactive level at the next output update. The outputs stay forced until the first overflow at which the break condition is gone.

Access goes through a byte-wide register port. Writes take effect at the clock edge. Read data is registered and appears the cycle after the read strobe.

Top module: `pwm_reload_timer`

## Requirements
- R1: After a synchronous reset, the reload, enable, duty, polarity and break registers read 0, and pwm_out and pwm_oe are 0.
- R2: The counter advances by one each cycle. In the cycle after it holds 0xFFF, it holds the reload value, so the period is 4096 minus the reload value.
- R3: Address 0 bits 3:0 hold reload bits 11:8 and address 1 holds reload bits 7:0. The unused bits of address 0 read 0. Read data appears on rdata the cycle after rd_en.
- R4: For an enabled channel with polarity 0, the output is high while the counter is below the channel's active duty value and low otherwise. pwm_out and pwm_oe are registered from the counter value of the previous cycle.
- R5: Channel c's duty value is written at address 4+2c (bits 3:0 are duty bits 11:8) and address 5+2c (duty bits 7:0). It becomes the active compare value only at overflow.
- R6: Address 2 bits 3:0 are the channel enables, bit c for channel c. A new value takes effect only at overflow. A disabled channel drives pwm_oe low and pwm_out low.
- R7: Bit 1 of channel c's status register (address 12+c) is its polarity. When it is 1, the output is inverted from the next output update onward.
- R8: Bit 0 of the status register is the compare flag. It is set when the counter equals the active duty value. A read of the status register returns the flag and then clears it, but a match in the same cycle as the read leaves it set. Bits 7:2 read 0.
- R9: Bit 0 of address 3 is the break bit. It is set in every cycle that brk_n is low, and a software write of 0 in such a cycle does not clear it. Software can write it to 1 or 0. Bits 7:1 read 0.
- R10: While brk_n is low or the break bit is 1, every enabled output is driven to its inactive level, which equals its polarity bit, from the next output update. The forcing persists until the first overflow at which brk_n is high and the break bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_n | input | 1 | Break request, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pwm_out | output | 4 | PWM levels, one per channel |
| pwm_oe | output | 4 | Per-channel pin drive enable |

## Verification
Two events can fall in the same cycle: the hardware setting of a compare flag, and the clearing of that flag by a status read. The bench waits until its reference counter sits on a channel's duty value and raises rd_en in exactly that cycle. It then reads the register again at once and expects the flag still set, because the set must win over the clear. A second overlap happens when brk_n is low in the same cycle that software writes 0 to the break bit. That case is judged by reading the bit back as 1 and by the outputs staying at their inactive levels.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  // Fixed register addresses; channel blocks follow from these.
  localparam int ADR_RLD_HI  = 0;
  localparam int ADR_RLD_LO  = 1;
  localparam int ADR_ENABLE  = 2;
  localparam int ADR_BREAK   = 3;
  localparam int ADR_DUTY0   = 4;   // duty hi at +2c, duty lo at +2c+1
  // Bit positions inside the status and break registers.
  localparam int BIT_FLAG    = 0;
  localparam int BIT_POL     = 1;
  localparam int BIT_BREAK   = 0;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign ovf = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ovf) cnt <= reload;
    else          cnt <= cnt + 1'b1;
  end

  // R2: wrap loads the reload value
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == $past(reload)));
  // R2: otherwise a single step up
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovf,
  input  logic [CNT_W-1:0] duty_sw,
  input  logic             en_sw,
  input  logic             pol,
  input  logic             force_out,
  input  logic             csr_rd,
  output logic             pwm_q,
  output logic             oe_q,
  output logic             flag
);
  logic [CNT_W-1:0] duty_act;
  logic             en_act;
  logic             match;
  logic             raw_lvl;

  assign match   = (cnt == duty_act);
  assign raw_lvl = (cnt < duty_act);

  // Active settings change only at the period boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      en_act   <= 1'b0;
    end else if (ovf) begin
      duty_act <= duty_sw;
      en_act   <= en_sw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= en_act;
      if (!en_act)        pwm_q <= 1'b0;
      else if (force_out) pwm_q <= pol;
      else                pwm_q <= raw_lvl ^ pol;
    end
  end

  // Hardware set has priority over the read-clear.
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (match)  flag <= 1'b1;
    else if (csr_rd) flag <= 1'b0;
  end

  a_r5_duty_held: assert property (@(posedge clk) disable iff (rst)
    !ovf |=> $stable(duty_act));
  a_r6_off_low: assert property (@(posedge clk) disable iff (rst)
    !en_act |=> (pwm_q == 1'b0 && oe_q == 1'b0));
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    match |=> flag);
  a_r10_forced: assert property (@(posedge clk) disable iff (rst)
    (en_act && force_out) |=> (pwm_q == $past(pol)));
endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         brk_n,
  input  logic [NUM_CH-1:0]            flags,
  output logic [DATA_W-1:0]            rdata,
  output logic [CNT_W-1:0]             reload,
  output logic [NUM_CH-1:0][CNT_W-1:0] duty_sw,
  output logic [NUM_CH-1:0]            en_sw,
  output logic [NUM_CH-1:0]            pol,
  output logic                         brk_bit,
  output logic [NUM_CH-1:0]            csr_rd
);
  localparam int HI_W     = CNT_W - DATA_W;
  localparam int ADR_CSR0 = ADR_DUTY0 + 2 * NUM_CH;

  logic [DATA_W-1:0] rd_mux;
  int                a;

  assign a = int'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload  <= '0;
      duty_sw <= '0;
      en_sw   <= '0;
      pol     <= '0;
    end else if (wr_en) begin
      if (a == ADR_RLD_HI) reload[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (a == ADR_RLD_LO) reload[DATA_W-1:0]     <= wdata;
      if (a == ADR_ENABLE) en_sw                  <= wdata[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (a == ADR_DUTY0 + 2 * c)     duty_sw[c][CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        if (a == ADR_DUTY0 + 2 * c + 1) duty_sw[c][DATA_W-1:0]     <= wdata;
        if (a == ADR_CSR0 + c)          pol[c]                     <= wdata[BIT_POL];
      end
    end
  end

  // Pin low overrides any software write.
  always_ff @(posedge clk) begin
    if (rst)                             brk_bit <= 1'b0;
    else if (!brk_n)                     brk_bit <= 1'b1;
    else if (wr_en && a == ADR_BREAK)    brk_bit <= wdata[BIT_BREAK];
  end

  always_comb begin
    rd_mux = '0;
    if (a == ADR_RLD_HI) rd_mux[HI_W-1:0]   = reload[CNT_W-1:DATA_W];
    if (a == ADR_RLD_LO) rd_mux             = reload[DATA_W-1:0];
    if (a == ADR_ENABLE) rd_mux[NUM_CH-1:0] = en_sw;
    if (a == ADR_BREAK)  rd_mux[BIT_BREAK]  = brk_bit;
    for (int c = 0; c < NUM_CH; c++) begin
      if (a == ADR_DUTY0 + 2 * c)     rd_mux[HI_W-1:0] = duty_sw[c][CNT_W-1:DATA_W];
      if (a == ADR_DUTY0 + 2 * c + 1) rd_mux           = duty_sw[c][DATA_W-1:0];
      if (a == ADR_CSR0 + c) begin
        rd_mux[BIT_FLAG] = flags[c];
        rd_mux[BIT_POL]  = pol[c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) csr_rd[c] = rd_en && (a == ADR_CSR0 + c);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r9_pin_sets: assert property (@(posedge clk) disable iff (rst)
    !brk_n |=> brk_bit);
  a_r3_rd_latency: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int CNT_W  = 12,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brk_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic [CNT_W-1:0]             cnt;
  logic                         ovf;
  logic [CNT_W-1:0]             reload;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_sw;
  logic [NUM_CH-1:0]            en_sw;
  logic [NUM_CH-1:0]            pol;
  logic [NUM_CH-1:0]            flags;
  logic [NUM_CH-1:0]            csr_rd;
  logic                         brk_bit;
  logic                         brk_now;
  logic                         brk_hold;
  logic                         force_out;

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .reload(reload), .cnt(cnt), .ovf(ovf));

  pwm_reg_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .brk_n(brk_n), .flags(flags), .rdata(rdata),
    .reload(reload), .duty_sw(duty_sw), .en_sw(en_sw), .pol(pol),
    .brk_bit(brk_bit), .csr_rd(csr_rd));

  // Break acts from the raw pin too, so forcing starts at the next update.
  assign brk_now   = brk_bit | ~brk_n;
  assign force_out = brk_now | brk_hold;

  always_ff @(posedge clk) begin
    if (rst)          brk_hold <= 1'b0;
    else if (brk_now) brk_hold <= 1'b1;
    else if (ovf)     brk_hold <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt), .ovf(ovf),
      .duty_sw(duty_sw[c]), .en_sw(en_sw[c]), .pol(pol[c]),
      .force_out(force_out), .csr_rd(csr_rd[c]),
      .pwm_q(pwm_out[c]), .oe_q(pwm_oe[c]), .flag(flags[c]));
  end

  a_r10_hold_until_ovf: assert property (@(posedge clk) disable iff (rst)
    (brk_hold && !ovf) |=> brk_hold);
endmodule

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       brk_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] pwm_out, pwm_oe;

  pwm_reload_timer uut (.clk(clk), .rst(rst), .brk_n(brk_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // Reference model, advanced at each rising edge from the requirements.
  logic [11:0] mcnt, mrld;
  logic [11:0] mduty_sw [4];
  logic [11:0] mduty_act[4];
  logic [3:0]  men_sw, men_act, mpol, mflag, mout, moe;
  logic        mbrk, mhold, rd_chk;
  logic [7:0]  mrd;

  function automatic logic [7:0] rd_model(input int a);
    logic [7:0] v = '0;
    if (a == 0) v = {4'h0, mrld[11:8]};
    if (a == 1) v = mrld[7:0];
    if (a == 2) v = {4'h0, men_sw};
    if (a == 3) v = {7'h0, mbrk};
    for (int c = 0; c < 4; c++) begin
      if (a == 4 + 2 * c) v = {4'h0, mduty_sw[c][11:8]};
      if (a == 5 + 2 * c) v = mduty_sw[c][7:0];
      if (a == 12 + c)    v = {6'h0, mpol[c], mflag[c]};
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mcnt = '0; mrld = '0; men_sw = '0; men_act = '0; mpol = '0; mflag = '0;
      mout = '0; moe = '0; mbrk = 0; mhold = 0; rd_chk = 0; mrd = '0;
      for (int c = 0; c < 4; c++) begin mduty_sw[c] = '0; mduty_act[c] = '0; end
    end else begin
      logic ovf, bnow, frc;
      int a;
      a = int'(addr);
      ovf = (mcnt == 12'hFFF);
      bnow = mbrk | ~brk_n;
      frc = bnow | mhold;
      rd_chk = rd_en;
      if (rd_en) mrd = rd_model(a);
      for (int c = 0; c < 4; c++) begin
        mout[c] = men_act[c] ? (frc ? mpol[c] : ((mcnt < mduty_act[c]) ^ mpol[c])) : 1'b0;
        moe[c]  = men_act[c];
        if (mcnt == mduty_act[c])     mflag[c] = 1'b1;
        else if (rd_en && a == 12 + c) mflag[c] = 1'b0;
      end
      if (bnow) mhold = 1'b1; else if (ovf) mhold = 1'b0;
      if (ovf) begin
        mcnt = mrld; men_act = men_sw;
        for (int c = 0; c < 4; c++) mduty_act[c] = mduty_sw[c];
      end else mcnt = mcnt + 1'b1;
      if (!brk_n) mbrk = 1'b1; else if (wr_en && a == 3) mbrk = wdata[0];
      if (wr_en) begin
        if (a == 0) mrld[11:8] = wdata[3:0];
        if (a == 1) mrld[7:0]  = wdata;
        if (a == 2) men_sw     = wdata[3:0];
        for (int c = 0; c < 4; c++) begin
          if (a == 4 + 2 * c) mduty_sw[c][11:8] = wdata[3:0];
          if (a == 5 + 2 * c) mduty_sw[c][7:0]  = wdata;
          if (a == 12 + c)    mpol[c]           = wdata[1];
        end
      end
    end
  end

  task automatic check8(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", t, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check8({tag, " pwm_out"}, {4'h0, pwm_out}, {4'h0, mout});
      check8({tag, " pwm_oe"},  {4'h0, pwm_oe},  {4'h0, moe});
      if (rd_chk) check8({tag, " rdata"}, rdata, mrd);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd_now(input int a);
    rd_en = 1; addr = 4'(a);
    @(negedge clk); rd_en = 0;
  endtask
  task automatic rd(input int a);
    @(negedge clk); rd_now(a);
  endtask
  task automatic wait_cnt(input logic [11:0] v);
    do @(negedge clk); while (mcnt != v);
  endtask
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_duty(input int c, input logic [11:0] d);
    wr(4 + 2 * c, {4'h0, d[11:8]}); wr(5 + 2 * c, d[7:0]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset values through the register port
    tag = "R1";
    for (int a = 0; a < 12; a++) rd(a);
    // R3: reload split, unused high bits
    tag = "R3";
    wr(0, 8'hFF); wr(1, 8'hF0); rd(0); rd(1);
    // R5, R6, R7 setup
    tag = "R5";
    set_duty(0, 12'hFF4); set_duty(1, 12'hFF0);
    set_duty(2, 12'hFFF); set_duty(3, 12'hFF8);
    for (int a = 4; a < 12; a++) rd(a);
    tag = "R6"; wr(2, 8'h0F); rd(2);
    tag = "R7"; wr(15, 8'h02);
    // R2: first long pass to 0xFFF, then reload periods
    tag = "R2"; wait_cnt(12'hFFF); run(40);
    tag = "R4"; run(48);
    // R8: flag reads, reserved bits, same-cycle set and clear
    tag = "R8";
    for (int c = 0; c < 4; c++) begin rd(12 + c); rd(12 + c); end
    wait_cnt(12'hFF4); rd_now(12); rd_now(12);
    wait_cnt(12'hFF8); rd_now(15); rd_now(15); rd(13);
    // R5: mid-period duty change deferred to overflow
    tag = "R5"; wait_cnt(12'hFF2); set_duty(0, 12'hFFA); run(40);
    // R6: mid-period disable deferred to overflow
    tag = "R6"; wait_cnt(12'hFF3); wr(2, 8'h05); run(40); wr(2, 8'h0F); run(34);
    // R7: polarity flip
    tag = "R7"; wait_cnt(12'hFF6); wr(12, 8'h02); run(36); wr(12, 8'h00); run(20);
    // R9: pin sets bit, pin wins over write of 0, reserved bits
    tag = "R9";
    wait_cnt(12'hFF5);
    @(negedge clk); brk_n = 0; wr_en = 1; addr = 4'd3; wdata = 8'h00;
    @(negedge clk); wr_en = 0;
    @(negedge clk); brk_n = 1;
    rd(3);
    // R10: forced until overflow after break clears
    tag = "R10"; run(8); wr(3, 8'hFE); rd(3); run(40);
    tag = "R9"; wr(3, 8'hFF); rd(3);
    tag = "R10"; run(30); wait_cnt(12'hFF7); wr(3, 8'h00); run(40);
    wait_cnt(12'hFF9); brk_n = 0; @(negedge clk); brk_n = 1; wr(3, 8'h00); run(40);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule